// File: doc/BRIEF.md
# Asynchronous Strobe Bus Slave

This block lets an external processor reach an internal register bank and a shared memory array over an asynchronous bus whose strobes are active low. Two static configuration inputs choose the bus shape. One selects whether the address travels on its own lines or shares the data lines behind an address-latch pulse. The other selects a 32-bit or a 16-bit data path. Chip select and data strobe pass through a two-stage synchronizer. The block then answers each access with an active-low ready that it drives for as long as the strobe stays low.

On the 16-bit path a pair of half-word accesses maps onto one 32-bit internal word. The first half read fetches the whole word and keeps the other half in a holding register, so the second half is returned with a shorter ready delay. The first half write is kept in a staging register. The internal word is written only when the opposite half of the same word arrives, so a partial update is never visible.

Top module: `host_bus_slave`

## Requirements
- R1: When cfg_mux_i=0, the address comes from addr_i and the controls mem_sel_i, rnw_i and hi_half_i are used while the strobe is low. When cfg_mux_i=1, the address is taken from data_i[ADDR_W-1:0] and the controls are latched while ale_i is high. The last values before ale_i falls are kept, and addr_i is ignored.
- R2: mem_sel_i=1 steers the access to the memory array at word index addr[5:0]. mem_sel_i=0 steers it to the register bank at index addr[3:0]. The two stores are independent.
- R3: Let edge 0 be the first rising clock edge at which strb_ni is low. For a 32-bit read, or for a 16-bit read that is not a pending second half, rdy_no goes low after edge 3.
- R4: For a write, or for the second half of a 16-bit read pair, rdy_no goes low after edge 2.
- R5: Let edge 0 be the first rising edge at which strb_ni is high again. rdy_no returns high after edge 2 and is high at all other times.
- R6: If cs_ni is high when the strobe falls, no ready is given and neither storage nor half-word state changes.
- R7: In 16-bit mode, hi_half_i=1 selects bits 31:16 and hi_half_i=0 selects bits 15:0. Read data appears on rdata_o[15:0] with rdata_o[31:16]=0. A read of the opposite half of the same word and store, done next, returns the held half.
- R8: Any write clears the read holding register. A 16-bit read that does not match the held half is served as a first read.
- R9: A first 16-bit write is staged and does not change the internal word. The word is written in full when the opposite half of the same word and store arrives.
- R10: A 16-bit write that does not complete the staged pair replaces the staged half. The earlier staged half is discarded.
- R11: rdata_oe_o is high exactly while cs_ni is low, strb_ni is low and rnw_i is high.
- R12: After reset, rdy_no is high, rdata_o is zero and every stored word is zero. A 32-bit write stores all of data_i, and a 32-bit read returns the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mux_i | input | 1 | 1: address shares the data lines |
| cfg_half_i | input | 1 | 1: 16-bit data path |
| cs_ni | input | 1 | Chip select, active low |
| strb_ni | input | 1 | Data strobe, active low |
| ale_i | input | 1 | Address latch enable (multiplexed bus) |
| rnw_i | input | 1 | 1: read, 0: write |
| mem_sel_i | input | 1 | 1: memory array, 0: register bank |
| hi_half_i | input | 1 | Half select for 16-bit accesses |
| addr_i | input | ADDR_W | Address lines (separate bus) |
| data_i | input | DATA_W | Write data; address phase when multiplexed |
| rdata_o | output | DATA_W | Read data |
| rdata_oe_o | output | 1 | Read data drive enable |
| rdy_no | output | 1 | Ready, active low |

## Verification
Counted from the first rising edge that sees the strobe low, ready is due after edge 3 for a fetching read and after edge 2 for a write or a held second half. It is released after edge 2 counted from the strobe's return high. The bench model produces the expected ready level for every cycle. The ready output is compared on each clock, a quarter period after the rising edge. Read data is checked on the falling edge after ready falls, once the returned word has been registered. The drive enable is combinational and is checked 1 ns after the strobe changes.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READY} seq_st_e;

  typedef struct packed {
    logic mem;
    logic rnw;
    logic hi;
  } bus_ctl_t;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '1;
        else         chain_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '1;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hbs_capture.sv
module hbs_capture
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_i,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] sep_addr_i,
  input  logic [ADDR_W-1:0] mux_addr_i,
  input  bus_ctl_t          ctl_i,
  output logic [ADDR_W-1:0] addr_o,
  output bus_ctl_t          ctl_o
);
  logic [ADDR_W-1:0] lat_addr_q;
  bus_ctl_t          lat_ctl_q;

  // lines are held stable for the whole latch-enable window
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lat_addr_q <= '0;
      lat_ctl_q  <= '0;
    end else if (ale_i) begin
      lat_addr_q <= mux_addr_i;
      lat_ctl_q  <= ctl_i;
    end

  assign addr_o = mux_i ? lat_addr_q : sep_addr_i;
  assign ctl_o  = mux_i ? lat_ctl_q  : ctl_i;
endmodule

// File: rtl/hbs_store.sv
module hbs_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [IW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] word_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else if (we_i) begin
      word_q[wa_i] <= wd_i;
    end

  assign rd_o = word_q[ra_i];
endmodule

// File: rtl/hbs_halfword.sv
module hbs_halfword #(
  parameter int ADDR_W = 8,
  parameter int HW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_mem_i,
  input  logic              cmp_hi_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [HW-1:0]     wr_half_i,
  input  logic              hold_ld_i,
  input  logic              hold_ld_mem_i,
  input  logic              hold_ld_hi_i,
  input  logic [ADDR_W-1:0] hold_ld_addr_i,
  input  logic [HW-1:0]     hold_ld_half_i,
  input  logic              hold_clr_i,
  input  logic              stage_ld_i,
  input  logic              stage_clr_i,
  output logic              hold_hit_o,
  output logic [HW-1:0]     hold_half_o,
  output logic              stage_hit_o,
  output logic              stage_vld_o,
  output logic [HW-1:0]     stage_half_o
);
  logic              hold_vld_q, hold_mem_q, hold_hi_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [HW-1:0]     hold_half_q;
  logic              stage_vld_q, stage_mem_q, stage_hi_q;
  logic [ADDR_W-1:0] stage_addr_q;
  logic [HW-1:0]     stage_half_q;

  // hold_hi_q records the half still owed to the host
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_mem_q  <= 1'b0;
      hold_hi_q   <= 1'b0;
      hold_addr_q <= '0;
      hold_half_q <= '0;
    end else if (hold_ld_i) begin
      hold_vld_q  <= 1'b1;
      hold_mem_q  <= hold_ld_mem_i;
      hold_hi_q   <= ~hold_ld_hi_i;
      hold_addr_q <= hold_ld_addr_i;
      hold_half_q <= hold_ld_half_i;
    end else if (hold_clr_i) begin
      hold_vld_q  <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stage_vld_q  <= 1'b0;
      stage_mem_q  <= 1'b0;
      stage_hi_q   <= 1'b0;
      stage_addr_q <= '0;
      stage_half_q <= '0;
    end else if (stage_ld_i) begin
      stage_vld_q  <= 1'b1;
      stage_mem_q  <= cmp_mem_i;
      stage_hi_q   <= cmp_hi_i;
      stage_addr_q <= cmp_addr_i;
      stage_half_q <= wr_half_i;
    end else if (stage_clr_i) begin
      stage_vld_q  <= 1'b0;
    end

  assign hold_hit_o   = hold_vld_q && (hold_mem_q == cmp_mem_i) &&
                        (hold_addr_q == cmp_addr_i) && (hold_hi_q == cmp_hi_i);
  assign hold_half_o  = hold_half_q;
  assign stage_hit_o  = stage_vld_q && (stage_mem_q == cmp_mem_i) &&
                        (stage_addr_q == cmp_addr_i) && (stage_hi_q != cmp_hi_i);
  assign stage_vld_o  = stage_vld_q;
  assign stage_half_o = stage_half_q;
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave
  import hbs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int REG_WORDS = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mux_i,
  input  logic              cfg_half_i,
  input  logic              cs_ni,
  input  logic              strb_ni,
  input  logic              ale_i,
  input  logic              rnw_i,
  input  logic              mem_sel_i,
  input  logic              hi_half_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              rdy_no
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NSTORE = 2;

  logic [1:0]        sync_q;
  logic              cs_s, strb_s, strb_s_d, det_fall;
  bus_ctl_t          ctl_raw, cur_ctl;
  logic [ADDR_W-1:0] cur_addr;
  seq_st_e           st_q;
  logic              in_idle, in_fetch, go;
  logic              rdy_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_mem_q, req_hi_q;
  logic              hold_hit, stage_hit, stage_vld;
  logic [HALF_W-1:0] hold_half, stage_half;
  logic              rd_sec, long_req, wr_go, wr_stage, wr_commit, we_any;
  logic              hold_ld, hold_clr;
  logic [DATA_W-1:0] wr_word, fetched;
  logic [HALF_W-1:0] fetch_half, keep_half;
  logic [DATA_W-1:0] rd_word [NSTORE];

  hbs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, strb_ni}),
    .q_o   (sync_q)
  );
  assign cs_s   = sync_q[1];
  assign strb_s = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) strb_s_d <= 1'b1;
    else         strb_s_d <= strb_s;

  assign det_fall = strb_s_d & ~strb_s;

  assign ctl_raw = {mem_sel_i, rnw_i, hi_half_i};

  hbs_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mux_i     (cfg_mux_i),
    .ale_i     (ale_i),
    .sep_addr_i(addr_i),
    .mux_addr_i(data_i[ADDR_W-1:0]),
    .ctl_i     (ctl_raw),
    .addr_o    (cur_addr),
    .ctl_o     (cur_ctl)
  );

  assign in_idle  = (st_q == ST_IDLE);
  assign in_fetch = (st_q == ST_FETCH);
  assign go       = in_idle & det_fall & ~cs_s;

  // access classification at the detected strobe fall
  assign rd_sec    = cfg_half_i & hold_hit;
  assign long_req  = cur_ctl.rnw & ~rd_sec;
  assign wr_go     = go & ~cur_ctl.rnw;
  assign wr_commit = wr_go & cfg_half_i & stage_hit;
  assign wr_stage  = wr_go & cfg_half_i & ~stage_hit;
  assign we_any    = wr_go & (~cfg_half_i | stage_hit);
  assign hold_ld   = in_fetch & cfg_half_i;
  assign hold_clr  = (go & cur_ctl.rnw & rd_sec) | wr_go;

  assign wr_word = !cfg_half_i ? data_i :
                   cur_ctl.hi  ? {data_i[HALF_W-1:0], stage_half} :
                                 {stage_half, data_i[HALF_W-1:0]};

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam int DEPTH = (g == 0) ? REG_WORDS : MEM_WORDS;
    localparam int IW    = $clog2(DEPTH);
    hbs_store #(.DEPTH(DEPTH), .DW(DATA_W)) u_store (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (we_any && (cur_ctl.mem == 1'(g))),
      .wa_i  (cur_addr[IW-1:0]),
      .wd_i  (wr_word),
      .ra_i  (req_addr_q[IW-1:0]),
      .rd_o  (rd_word[g])
    );
  end

  assign fetched    = req_mem_q ? rd_word[1] : rd_word[0];
  assign fetch_half = req_hi_q ? fetched[DATA_W-1:HALF_W] : fetched[HALF_W-1:0];
  assign keep_half  = req_hi_q ? fetched[HALF_W-1:0] : fetched[DATA_W-1:HALF_W];

  hbs_halfword #(.ADDR_W(ADDR_W), .HW(HALF_W)) u_halfword (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmp_mem_i     (cur_ctl.mem),
    .cmp_hi_i      (cur_ctl.hi),
    .cmp_addr_i    (cur_addr),
    .wr_half_i     (data_i[HALF_W-1:0]),
    .hold_ld_i     (hold_ld),
    .hold_ld_mem_i (req_mem_q),
    .hold_ld_hi_i  (req_hi_q),
    .hold_ld_addr_i(req_addr_q),
    .hold_ld_half_i(keep_half),
    .hold_clr_i    (hold_clr),
    .stage_ld_i    (wr_stage),
    .stage_clr_i   (wr_commit),
    .hold_hit_o    (hold_hit),
    .hold_half_o   (hold_half),
    .stage_hit_o   (stage_hit),
    .stage_vld_o   (stage_vld),
    .stage_half_o  (stage_half)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rdy_q      <= 1'b1;
      rdata_q    <= '0;
      req_addr_q <= '0;
      req_mem_q  <= 1'b0;
      req_hi_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          req_addr_q <= cur_addr;
          req_mem_q  <= cur_ctl.mem;
          req_hi_q   <= cur_ctl.hi;
          if (long_req) begin
            st_q <= ST_FETCH;
          end else begin
            rdy_q <= 1'b0;
            st_q  <= ST_READY;
            if (cur_ctl.rnw) rdata_q <= {{HALF_W{1'b0}}, hold_half};
          end
        end
        ST_FETCH: begin
          rdata_q <= cfg_half_i ? {{HALF_W{1'b0}}, fetch_half} : fetched;
          rdy_q   <= 1'b0;
          st_q    <= ST_READY;
        end
        ST_READY: if (strb_s) begin
          rdy_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end

  assign rdata_o    = rdata_q;
  assign rdata_oe_o = ~cs_ni & ~strb_ni & rnw_i;
  assign rdy_no     = rdy_q;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic in_idle_i,
  input logic in_fetch_i,
  input logic det_i,
  input logic cs_s_i,
  input logic strb_s_i,
  input logic long_i,
  input logic we_i,
  input logic half_i,
  input logic stage_vld_i,
  input logic rdy_ni
);
  assert_long_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fetch_i |=> !rdy_ni);

  assert_short_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle_i && det_i && !cs_s_i && !long_i) |=> !rdy_ni);

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_s_i && !rdy_ni) |=> rdy_ni);

  assert_unselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle_i && det_i && cs_s_i) |=> rdy_ni);

  assert_pair_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && half_i) |=> !stage_vld_i);
endmodule

bind host_bus_slave hbs_checker u_hbs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_idle_i  (in_idle),
  .in_fetch_i (in_fetch),
  .det_i      (det_fall),
  .cs_s_i     (cs_s),
  .strb_s_i   (strb_s),
  .long_i     (long_req),
  .we_i       (we_any),
  .half_i     (cfg_half_i),
  .stage_vld_i(stage_vld),
  .rdy_ni     (rdy_no)
);

// File: tb/test_host_bus_slave.sv
module test_host_bus_slave;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_mux_i = 1'b0, cfg_half_i = 1'b0;
  logic        cs_ni = 1'b1, strb_ni = 1'b1, ale_i = 1'b0;
  logic        rnw_i = 1'b1, mem_sel_i = 1'b0, hi_half_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] data_i = '0;
  logic [31:0] rdata_o;
  logic        rdata_oe_o, rdy_no;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  logic exp_rdy_n = 1'b1;

  // reference model state
  logic [31:0] m_reg [16];
  logic [31:0] m_mem [64];
  bit          hv, hmem, hhi, sv, smem, shi;
  logic [7:0]  haddr, saddr;
  logic [15:0] hdat, sdat;

  always #10 clk = ~clk;

  host_bus_slave i_host_bus_slave (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_mux_i(cfg_mux_i), .cfg_half_i(cfg_half_i),
    .cs_ni(cs_ni), .strb_ni(strb_ni), .ale_i(ale_i), .rnw_i(rnw_i),
    .mem_sel_i(mem_sel_i), .hi_half_i(hi_half_i), .addr_i(addr_i), .data_i(data_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .rdy_no(rdy_no)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ready level compared on every clock (R3 R4 R5 R6)
  always @(posedge clk) begin
    #5;
    if (cmp_en && !done)
      chk(rdy_no === exp_rdy_n, "R3/R4/R5/R6 ready level", {31'b0, rdy_no}, {31'b0, exp_rdy_n});
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 run did not complete act=0 exp=1");
      summary();
    end
  end

  function automatic logic [31:0] rd_store(input bit mem, input logic [7:0] a);
    return mem ? m_mem[a[5:0]] : m_reg[a[3:0]];
  endfunction

  task automatic wr_store(input bit mem, input logic [7:0] a, input logic [31:0] w);
    if (mem) m_mem[a[5:0]] = w; else m_reg[a[3:0]] = w;
  endtask

  task automatic acc(input bit rnw, input bit mem, input logic [7:0] a, input bit hi,
                     input logic [31:0] wd, input bit sel, input string tag);
    bit lng;
    logic [31:0] er, w;
    lng = 1'b0; er = '0;
    if (sel) begin
      if (rnw) begin
        if (cfg_half_i && hv && hmem == mem && haddr == a && hhi == hi) begin
          er = {16'h0, hdat}; hv = 1'b0;
        end else if (cfg_half_i) begin
          lng = 1'b1; w = rd_store(mem, a);
          er = {16'h0, hi ? w[31:16] : w[15:0]};
          hv = 1'b1; hmem = mem; haddr = a; hhi = !hi; hdat = hi ? w[15:0] : w[31:16];
        end else begin
          lng = 1'b1; er = rd_store(mem, a);
        end
      end else begin
        hv = 1'b0;
        if (!cfg_half_i) wr_store(mem, a, wd);
        else if (sv && smem == mem && saddr == a && shi != hi) begin
          wr_store(mem, a, hi ? {wd[15:0], sdat} : {sdat, wd[15:0]}); sv = 1'b0;
        end else begin
          sv = 1'b1; smem = mem; saddr = a; shi = hi; sdat = wd[15:0];
        end
      end
    end
    @(negedge clk);
    cs_ni = !sel; rnw_i = rnw; mem_sel_i = mem; hi_half_i = hi;
    if (cfg_mux_i) begin
      addr_i = ~a; data_i = {24'h0, a}; ale_i = 1'b1;
      @(negedge clk);
      ale_i = 1'b0; data_i = wd; mem_sel_i = !mem; hi_half_i = !hi;
      @(negedge clk);
    end else begin
      addr_i = a; data_i = wd;
    end
    strb_ni = 1'b0;
    #1;
    chk(rdata_oe_o === (sel && rnw), {tag, " R11 drive enable"}, {31'b0, rdata_oe_o}, {31'b0, sel && rnw});
    repeat (lng ? 4 : 3) @(posedge clk);
    if (sel) exp_rdy_n = 1'b0;
    @(negedge clk);
    if (sel && rnw) chk(rdata_o === er, tag, rdata_o, er);
    strb_ni = 1'b1;
    repeat (3) @(posedge clk);
    exp_rdy_n = 1'b1;
    @(negedge clk);
    cs_ni = 1'b1; ale_i = 1'b0;
    #1;
    chk(rdata_oe_o === 1'b0, "R11 idle drive enable", {31'b0, rdata_oe_o}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    hv = 0; sv = 0; hmem = 0; hhi = 0; smem = 0; shi = 0;
    haddr = '0; saddr = '0; hdat = '0; sdat = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdy_no === 1'b1, "R12 reset ready", {31'b0, rdy_no}, 32'h1);
    chk(rdata_o === 32'h0, "R12 reset data", rdata_o, 32'h0);
    chk(rdata_oe_o === 1'b0, "R12 reset drive enable", {31'b0, rdata_oe_o}, 32'h0);
    cmp_en = 1'b1;

    // separate bus, 32-bit
    acc(1, 0, 8'd3, 0, 0, 1, "R12 reset contents");
    acc(0, 0, 8'd5, 0, 32'hA5A5_1234, 1, "R12 write reg");
    acc(0, 1, 8'd5, 0, 32'h0BAD_F00D, 1, "R2 write mem");
    acc(0, 1, 8'd40, 0, 32'hDEAD_BEEF, 1, "R2 write mem");
    acc(1, 0, 8'd5, 0, 0, 1, "R2 read reg");
    acc(1, 1, 8'd5, 0, 0, 1, "R2 read mem");
    acc(0, 0, 8'd5, 0, 32'h1111_1111, 0, "R6 unselected write");
    acc(1, 0, 8'd5, 0, 0, 1, "R6 after unselected write");

    // multiplexed, 32-bit
    cfg_mux_i = 1'b1;
    acc(0, 1, 8'd7, 0, 32'h7766_5544, 1, "R1 mux write");
    acc(1, 1, 8'd7, 0, 0, 1, "R1 mux read");
    acc(1, 0, 8'd5, 0, 0, 1, "R1 mux read reg");

    // separate bus, 16-bit
    cfg_mux_i = 1'b0; cfg_half_i = 1'b1;
    acc(1, 0, 8'd5, 0, 0, 1, "R7 first low half");
    acc(1, 0, 8'd5, 1, 0, 1, "R7 held high half");
    acc(1, 0, 8'd5, 1, 0, 1, "R7 first high half");
    acc(1, 0, 8'd5, 0, 0, 1, "R7 held low half");
    acc(0, 1, 8'd40, 0, 32'h1111, 1, "R9 stage low");
    acc(1, 1, 8'd40, 0, 0, 1, "R9 word unchanged low");
    acc(1, 1, 8'd40, 1, 0, 1, "R9 word unchanged high");
    acc(0, 1, 8'd40, 1, 32'h2222, 1, "R9 commit high");
    acc(1, 1, 8'd40, 0, 0, 1, "R9 committed low");
    acc(1, 1, 8'd40, 1, 0, 1, "R9 committed high");
    acc(0, 0, 8'd9, 0, 32'hAAAA, 1, "R10 stage reg9");
    acc(0, 0, 8'd10, 1, 32'hBBBB, 1, "R10 restage reg10");
    acc(0, 0, 8'd10, 0, 32'hCCCC, 1, "R10 commit reg10");
    acc(1, 0, 8'd10, 0, 0, 1, "R10 reg10 low");
    acc(1, 0, 8'd10, 1, 0, 1, "R10 reg10 high");
    acc(1, 0, 8'd9, 0, 0, 1, "R10 reg9 untouched");
    acc(1, 0, 8'd9, 1, 0, 1, "R10 reg9 untouched high");
    acc(1, 1, 8'd5, 0, 0, 1, "R8 first read");
    acc(0, 0, 8'd12, 0, 32'h0001, 1, "R8 write between");
    acc(1, 1, 8'd5, 1, 0, 1, "R8 refetch after write");
    acc(1, 1, 8'd5, 1, 0, 1, "R8 first read again");
    acc(1, 0, 8'd5, 0, 0, 1, "R8 mismatched word");
    acc(0, 0, 8'd12, 1, 32'h0002, 1, "R9 commit reg12");
    acc(1, 0, 8'd5, 0, 0, 1, "R6 pair first");
    acc(1, 0, 8'd5, 1, 0, 0, "R6 unselected second");
    acc(1, 0, 8'd5, 1, 0, 1, "R6 held half kept");

    // multiplexed, 16-bit
    cfg_mux_i = 1'b1;
    acc(0, 1, 8'd20, 0, 32'h3333, 1, "R1 mux stage");
    acc(0, 1, 8'd20, 1, 32'h4444, 1, "R1 mux commit");
    acc(1, 1, 8'd20, 1, 0, 1, "R1 mux half read");
    acc(1, 1, 8'd20, 0, 0, 1, "R1 mux held half");

    // back to separate 32-bit
    cfg_mux_i = 1'b0; cfg_half_i = 1'b0;
    acc(1, 1, 8'd20, 0, 0, 1, "R12 full word from halves");
    acc(1, 0, 8'd12, 0, 0, 1, "R12 reg12 word");
    acc(1, 0, 8'd10, 0, 0, 1, "R12 reg10 word");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule